// File: doc/BRIEF.md
# Core Sandbox Address and Pin Guard

This block sits between a set of processor cores and a shared memory that is carved into one equal slice per core. Each core carries a one-bit restricted flag. A core that is not restricted reaches the whole shared memory with its address unchanged. A restricted core sees only a private window that starts at address zero. The block folds that window onto the core's own physical slice: the core number forms the upper address bits and the window offset forms the lower bits. An address beyond the window wraps back into it and can never reach another slice.

A single command port sets or clears the restricted flag of any core. Each command names the issuing core. A command from a restricted core is discarded. Restricted cores also lose their pin access. Their output-value and direction writes are gated off, and their pin reads return zero. Every blocked operation produces a registered one-cycle violation report that gives the offending core and the cause. Address translation and pin gating are purely combinational from the flag registers, so a change of mode applies to the first request after the command has been clocked in.

Top module: `core_sandbox_guard`

## Requirements
- R1: After synchronous reset every core is unrestricted, so every `phys_addr` lane equals its `req_addr` lane, and no violation is reported.
- R2: For an unrestricted core, the physical address equals the requested address over the full memory width, including addresses that fall inside other cores' slices.
- R3: For a restricted core `c`, the physical address is `{c, req_addr[SLICE_AW-1:0]}`. Address bits above the window are dropped, so the address wraps inside the core's own slice.
- R4: A command with `cmd_valid` high from an unrestricted `cmd_src` writes `cmd_set` (1 = restrict, 0 = release) into the flag of `cmd_tgt` at the clock edge. A request in the same cycle as the command is translated under the old mode, and requests from the next cycle on use the new mode.
- R5: A command whose `cmd_src` is restricted leaves every core's flag unchanged.
- R6: `pin_out_we_o` and `pin_dir_we_o` follow their inputs for unrestricted cores and are held at 0 for restricted cores.
- R7: A restricted core's `pin_rd_data` lane reads zero. An unrestricted core's lane equals `pin_in`.
- R8: A blocked operation raises `viol_valid` for exactly the cycle after the offending input cycle. The report carries `viol_core` and `viol_cause`, encoded as 1 = discarded mode command, 2 = blocked pin write (output or direction), 3 = restricted pin read, and 0 = none.
- R9: When several blocked operations occur in one cycle, only one is reported. Cause 1 ranks above cause 2, and cause 2 ranks above cause 3. Within a cause, the lowest core index wins.
- R10: In a cycle that follows one with no blocked operation, `viol_valid` is 0 and `viol_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_addr | input | N_CORES*MEM_AW | Per-core requested address, core c in lane c |
| phys_addr | output | N_CORES*MEM_AW | Per-core translated physical address |
| cmd_valid | input | 1 | Mode command strobe |
| cmd_src | input | CORE_W | Core issuing the command |
| cmd_tgt | input | CORE_W | Core whose flag is written |
| cmd_set | input | 1 | 1 restricts the target, 0 releases it |
| pin_out_we_i | input | N_CORES | Per-core pin output-value write request |
| pin_dir_we_i | input | N_CORES | Per-core pin direction write request |
| pin_out_we_o | output | N_CORES | Gated output-value write enables |
| pin_dir_we_o | output | N_CORES | Gated direction write enables |
| pin_rd_req | input | N_CORES | Per-core pin read request |
| pin_in | input | PIN_W | Shared pin input state |
| pin_rd_data | output | N_CORES*PIN_W | Per-core pin read data |
| viol_valid | output | 1 | Violation strobe |
| viol_core | output | CORE_W | Core that caused the reported violation |
| viol_cause | output | 2 | Violation cause code |

## Verification
The bench uses the default parameters: sixteen cores, a 15-bit window and eight pins, which gives a 19-bit physical address. With these values it can reach the top core's top address, where every physical bit is set. It can also check the wrap boundary at offset 0x8000, which folds back to the base of a slice. Restricting cores at both ends of the index range tests the lowest-index tie-break and the cause ranking in a single cycle.

// File: rtl/sbx_pkg.sv
package sbx_pkg;
    typedef enum logic [1:0] {
        VC_NONE   = 2'd0,
        VC_MODE   = 2'd1,
        VC_PIN_WR = 2'd2,
        VC_PIN_RD = 2'd3
    } viol_cause_e;
endpackage

// File: rtl/sbx_mode_regs.sv
module sbx_mode_regs #(
    parameter int N_CORES = 16,
    localparam int CORE_W = $clog2(N_CORES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [CORE_W-1:0]  cmd_src,
    input  logic [CORE_W-1:0]  cmd_tgt,
    input  logic               cmd_set,
    output logic [N_CORES-1:0] restricted_q,
    output logic               mode_blk
);
    logic src_free;
    assign src_free = !restricted_q[cmd_src];
    assign mode_blk = cmd_valid && !src_free;

    always_ff @(posedge clk) begin
        if (rst) begin
            restricted_q <= '0;
        end else if (cmd_valid && src_free) begin
            restricted_q[cmd_tgt] <= cmd_set;
        end
    end

    // R1: flags are clear after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> restricted_q == '0);
    // R5: a restricted source changes nothing
    p_locked_src_r5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && restricted_q[cmd_src]) |=> $stable(restricted_q));
    // R4: a command from a free source lands on its target
    p_cmd_applies_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !restricted_q[cmd_src]) |=> restricted_q[$past(cmd_tgt)] == $past(cmd_set));
endmodule

// File: rtl/sbx_addr_fold.sv
module sbx_addr_fold #(
    parameter int SLICE_AW = 15,
    parameter int CORE_W   = 4,
    parameter int CORE_ID  = 0,
    localparam int MEM_AW  = SLICE_AW + CORE_W
) (
    input  logic              restricted,
    input  logic [MEM_AW-1:0] addr_in,
    output logic [MEM_AW-1:0] addr_out
);
    localparam logic [CORE_W-1:0] SLICE_SEL = CORE_W'(CORE_ID);

    always_comb begin
        if (restricted) addr_out = {SLICE_SEL, addr_in[SLICE_AW-1:0]};
        else            addr_out = addr_in;
    end

    // R3: a folded address always lands in this core's slice
    always_comb begin
        if (restricted) begin
            p_fold_slice_r3: assert (addr_out[MEM_AW-1:SLICE_AW] == SLICE_SEL
                                     && addr_out[SLICE_AW-1:0] == addr_in[SLICE_AW-1:0]);
        end
    end
endmodule

// File: rtl/sbx_pin_gate.sv
module sbx_pin_gate #(
    parameter int N_CORES = 16,
    parameter int PIN_W   = 8
) (
    input  logic [N_CORES-1:0]       restricted,
    input  logic [N_CORES-1:0]       out_we_i,
    input  logic [N_CORES-1:0]       dir_we_i,
    input  logic [N_CORES-1:0]       rd_req,
    input  logic [PIN_W-1:0]         pin_in,
    output logic [N_CORES-1:0]       out_we_o,
    output logic [N_CORES-1:0]       dir_we_o,
    output logic [N_CORES*PIN_W-1:0] rd_data,
    output logic [N_CORES-1:0]       wr_blk,
    output logic [N_CORES-1:0]       rd_blk
);
    assign out_we_o = out_we_i & ~restricted;
    assign dir_we_o = dir_we_i & ~restricted;
    assign wr_blk   = (out_we_i | dir_we_i) & restricted;
    assign rd_blk   = rd_req & restricted;

    for (genvar c = 0; c < N_CORES; c++) begin : g_lane
        assign rd_data[c*PIN_W +: PIN_W] = restricted[c] ? '0 : pin_in;

        // R6/R7: no restricted lane leaks an enable or pin data
        always_comb begin
            if (restricted[c]) begin
                p_lane_quiet_r7: assert (rd_data[c*PIN_W +: PIN_W] == '0
                                         && !out_we_o[c] && !dir_we_o[c]);
            end
        end
    end
endmodule

// File: rtl/sbx_viol_encoder.sv
module sbx_viol_encoder
    import sbx_pkg::*;
#(
    parameter int N_CORES = 16,
    localparam int CORE_W = $clog2(N_CORES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               mode_blk,
    input  logic [CORE_W-1:0]  mode_src,
    input  logic [N_CORES-1:0] wr_blk,
    input  logic [N_CORES-1:0] rd_blk,
    output logic               viol_valid,
    output logic [CORE_W-1:0]  viol_core,
    output viol_cause_e        viol_cause
);
    logic              nxt_valid;
    logic [CORE_W-1:0] nxt_core;
    viol_cause_e       nxt_cause;

    always_comb begin
        nxt_valid = 1'b0;
        nxt_core  = '0;
        nxt_cause = VC_NONE;
        for (int i = N_CORES - 1; i >= 0; i--) begin
            if (rd_blk[i]) begin
                nxt_valid = 1'b1; nxt_core = CORE_W'(i); nxt_cause = VC_PIN_RD;
            end
        end
        if (wr_blk != '0) begin
            for (int i = N_CORES - 1; i >= 0; i--) begin
                if (wr_blk[i]) begin
                    nxt_valid = 1'b1; nxt_core = CORE_W'(i); nxt_cause = VC_PIN_WR;
                end
            end
        end
        if (mode_blk) begin
            nxt_valid = 1'b1; nxt_core = mode_src; nxt_cause = VC_MODE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            viol_valid <= 1'b0;
            viol_core  <= '0;
            viol_cause <= VC_NONE;
        end else begin
            viol_valid <= nxt_valid;
            viol_core  <= nxt_core;
            viol_cause <= nxt_cause;
        end
    end

    // R9: a discarded command outranks pin violations in the report
    p_mode_first_r9: assert property (@(posedge clk) disable iff (rst)
        mode_blk |=> viol_valid && viol_cause == VC_MODE && viol_core == $past(mode_src));
    // R10: a quiet cycle gives no report
    p_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        (!mode_blk && wr_blk == '0 && rd_blk == '0) |=> !viol_valid && viol_cause == VC_NONE);
    // R8: a strobe always carries a cause
    p_tagged_r8: assert property (@(posedge clk) disable iff (rst)
        viol_valid |-> viol_cause != VC_NONE);
endmodule

// File: rtl/core_sandbox_guard.sv
module core_sandbox_guard #(
    parameter int N_CORES  = 16,
    parameter int SLICE_AW = 15,
    parameter int PIN_W    = 8,
    localparam int CORE_W  = $clog2(N_CORES),
    localparam int MEM_AW  = SLICE_AW + CORE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_CORES*MEM_AW-1:0] req_addr,
    output logic [N_CORES*MEM_AW-1:0] phys_addr,
    input  logic                      cmd_valid,
    input  logic [CORE_W-1:0]         cmd_src,
    input  logic [CORE_W-1:0]         cmd_tgt,
    input  logic                      cmd_set,
    input  logic [N_CORES-1:0]        pin_out_we_i,
    input  logic [N_CORES-1:0]        pin_dir_we_i,
    output logic [N_CORES-1:0]        pin_out_we_o,
    output logic [N_CORES-1:0]        pin_dir_we_o,
    input  logic [N_CORES-1:0]        pin_rd_req,
    input  logic [PIN_W-1:0]          pin_in,
    output logic [N_CORES*PIN_W-1:0]  pin_rd_data,
    output logic                      viol_valid,
    output logic [CORE_W-1:0]         viol_core,
    output logic [1:0]                viol_cause
);
    logic [N_CORES-1:0] restricted_q;
    logic               mode_blk;
    logic [N_CORES-1:0] wr_blk;
    logic [N_CORES-1:0] rd_blk;
    sbx_pkg::viol_cause_e cause_e;

    sbx_mode_regs #(.N_CORES(N_CORES)) u_mode (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_src(cmd_src),
        .cmd_tgt(cmd_tgt), .cmd_set(cmd_set),
        .restricted_q(restricted_q), .mode_blk(mode_blk)
    );

    for (genvar c = 0; c < N_CORES; c++) begin : g_fold
        sbx_addr_fold #(.SLICE_AW(SLICE_AW), .CORE_W(CORE_W), .CORE_ID(c)) u_fold (
            .restricted(restricted_q[c]),
            .addr_in(req_addr[c*MEM_AW +: MEM_AW]),
            .addr_out(phys_addr[c*MEM_AW +: MEM_AW])
        );
    end

    sbx_pin_gate #(.N_CORES(N_CORES), .PIN_W(PIN_W)) u_pins (
        .restricted(restricted_q), .out_we_i(pin_out_we_i), .dir_we_i(pin_dir_we_i),
        .rd_req(pin_rd_req), .pin_in(pin_in), .out_we_o(pin_out_we_o),
        .dir_we_o(pin_dir_we_o), .rd_data(pin_rd_data), .wr_blk(wr_blk), .rd_blk(rd_blk)
    );

    sbx_viol_encoder #(.N_CORES(N_CORES)) u_viol (
        .clk(clk), .rst(rst), .mode_blk(mode_blk), .mode_src(cmd_src),
        .wr_blk(wr_blk), .rd_blk(rd_blk),
        .viol_valid(viol_valid), .viol_core(viol_core), .viol_cause(cause_e)
    );

    assign viol_cause = cause_e;
endmodule

// File: tb/core_sandbox_guard_bench.sv
module core_sandbox_guard_bench;
    localparam int N  = 16;
    localparam int SA = 15;
    localparam int PW = 8;
    localparam int CW = 4;
    localparam int AW = SA + CW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N*AW-1:0] req_addr = '0;
    logic [N*AW-1:0] phys_addr;
    logic cmd_valid = 1'b0;
    logic [CW-1:0] cmd_src = '0, cmd_tgt = '0;
    logic cmd_set = 1'b0;
    logic [N-1:0] pin_out_we_i = '0, pin_dir_we_i = '0, pin_rd_req = '0;
    logic [N-1:0] pin_out_we_o, pin_dir_we_o;
    logic [PW-1:0] pin_in = '0;
    logic [N*PW-1:0] pin_rd_data;
    logic viol_valid;
    logic [CW-1:0] viol_core;
    logic [1:0] viol_cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    core_sandbox_guard #(.N_CORES(N), .SLICE_AW(SA), .PIN_W(PW)) u_core_sandbox_guard (
        .clk(clk), .rst(rst), .req_addr(req_addr), .phys_addr(phys_addr),
        .cmd_valid(cmd_valid), .cmd_src(cmd_src), .cmd_tgt(cmd_tgt), .cmd_set(cmd_set),
        .pin_out_we_i(pin_out_we_i), .pin_dir_we_i(pin_dir_we_i),
        .pin_out_we_o(pin_out_we_o), .pin_dir_we_o(pin_dir_we_o),
        .pin_rd_req(pin_rd_req), .pin_in(pin_in), .pin_rd_data(pin_rd_data),
        .viol_valid(viol_valid), .viol_core(viol_core), .viol_cause(viol_cause)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] phys(int c);
        return 32'(phys_addr[c*AW +: AW]);
    endfunction

    task automatic set_addr(int c, logic [AW-1:0] a);
        req_addr[c*AW +: AW] = a;
    endtask

    task automatic mode_cmd(int src, int tgt, bit set);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_src = CW'(src); cmd_tgt = CW'(tgt); cmd_set = set;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        set_addr(9, 19'h5_ABCD);
        @(negedge clk); #1;
        chk("R1", "phys core9 after reset", phys(9), 32'h5ABCD);
        chk("R1", "viol_valid after reset", 32'(viol_valid), 0);
    endtask

    task automatic t_free_access;
        set_addr(3, 19'h2_9234);
        set_addr(0, 19'h7_FFFF);
        #1;
        chk("R2", "free core3 into slice 5", phys(3), 32'h29234);
        chk("R2", "free core0 top address", phys(0), 32'h7FFFF);
    endtask

    task automatic t_mode_timing;
        @(negedge clk);
        set_addr(5, 19'h4_1234);
        cmd_valid = 1'b1; cmd_src = 4'd0; cmd_tgt = 4'd5; cmd_set = 1'b1;
        #1;
        chk("R4", "same-cycle request keeps old mode", phys(5), 32'h41234);
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk("R4", "next-cycle request folded", phys(5), 32'h29234);
    endtask

    task automatic t_fold_wrap;
        set_addr(5, 19'h0_7FFF); #1;
        chk("R3", "window top", phys(5), 32'h2FFFF);
        set_addr(5, 19'h0_8000); #1;
        chk("R3", "wrap to slice base", phys(5), 32'h28000);
        mode_cmd(0, 15, 1'b1);
        set_addr(15, 19'h7_FFFF); #1;
        chk("R3", "core15 top", phys(15), 32'h7FFFF);
        mode_cmd(1, 0, 1'b1);
        set_addr(0, 19'h1_2345); #1;
        chk("R3", "core0 wraps to slice 0", phys(0), 32'h02345);
        mode_cmd(1, 0, 1'b0);
        #1;
        chk("R4", "core0 released", phys(0), 32'h12345);
    endtask

    task automatic t_locked_cmd;
        // core 5 restricted: try to restrict core 3 and to release itself
        @(negedge clk);
        cmd_valid = 1'b1; cmd_src = 4'd5; cmd_tgt = 4'd3; cmd_set = 1'b1;
        @(negedge clk);
        #1;
        chk("R8", "mode violation strobe", 32'(viol_valid), 1);
        chk("R8", "mode violation core", 32'(viol_core), 5);
        chk("R8", "mode violation cause", 32'(viol_cause), 1);
        cmd_tgt = 4'd5; cmd_set = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0;
        #1;
        chk("R5", "core3 still free", phys(3), 32'h29234);
        chk("R5", "core5 still restricted", phys(5), 32'h28000);
        @(negedge clk); #1;
        chk("R10", "strobe clears", 32'(viol_valid), 0);
        chk("R10", "cause clears", 32'(viol_cause), 0);
    endtask

    task automatic t_pins;
        pin_in = 8'hA5;
        pin_out_we_i = '1; pin_dir_we_i = '1;
        #1;
        // restricted now: cores 5 and 15
        chk("R6", "out enables gated", 32'(pin_out_we_o), 32'h7FDF);
        chk("R6", "dir enables gated", 32'(pin_dir_we_o), 32'h7FDF);
        chk("R7", "restricted core5 reads zero", 32'(pin_rd_data[5*PW +: PW]), 0);
        chk("R7", "free core4 reads pins", 32'(pin_rd_data[4*PW +: PW]), 32'hA5);
        @(negedge clk);
        pin_out_we_i = '0; pin_dir_we_i = '0;
        #1;
        chk("R8", "pin write strobe", 32'(viol_valid), 1);
        chk("R9", "lowest core for pin write", 32'(viol_core), 5);
        chk("R8", "pin write cause", 32'(viol_cause), 2);
    endtask

    task automatic t_priority;
        mode_cmd(0, 2, 1'b1);
        mode_cmd(0, 7, 1'b1);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_src = 4'd7; cmd_tgt = 4'd1; cmd_set = 1'b1;
        pin_out_we_i = 16'h0004; pin_rd_req = 16'h0080;
        @(negedge clk);
        cmd_valid = 1'b0;
        pin_out_we_i = 16'h0000; pin_dir_we_i = 16'h0080; pin_rd_req = 16'h0084;
        #1;
        chk("R9", "mode outranks pins: cause", 32'(viol_cause), 1);
        chk("R9", "mode outranks pins: core", 32'(viol_core), 7);
        @(negedge clk);
        pin_dir_we_i = '0; pin_rd_req = 16'h8080;
        #1;
        chk("R9", "write outranks read: cause", 32'(viol_cause), 2);
        chk("R9", "write outranks read: core", 32'(viol_core), 7);
        @(negedge clk);
        pin_rd_req = '0;
        #1;
        chk("R8", "read cause", 32'(viol_cause), 3);
        chk("R9", "lowest read core", 32'(viol_core), 7);
        @(negedge clk); #1;
        chk("R10", "idle after burst", 32'(viol_valid), 0);
        set_addr(1, 19'h4_0001); #1;
        chk("R5", "core1 not restricted by core7", phys(1), 32'h40001);
    endtask

    initial begin
        t_reset();
        t_free_access();
        t_mode_timing();
        t_fold_wrap();
        t_locked_cmd();
        t_pins();
        t_priority();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule